// File: doc/BRIEF.md
# I2C Transaction Master

This block is a single-master I2C controller that runs one complete bus transaction for each command it accepts. A command carries a 7-bit target address, a direction bit and a byte count. The block issues a start condition and shifts out the address byte with the direction bit appended. It then checks the target's acknowledge. After that it either writes the requested bytes, fetched one at a time from a valid/ready byte stream, or reads them and presents each one on a valid/ready output. Every transaction ends with a short phase that holds SDA low, followed by a stop condition.

The controller is built as a state machine that advances on half-period ticks of SCL. The SCL half-period is a parameter counted in system clocks. SDA is open drain: the block only ever pulls the line low or releases it. When the user side is slow, SCL is held low between bytes, which stretches the bus clock. If the target answers the address or a written byte with NACK, the transaction is cut short and a sticky error flag is raised. Software can then poll the target, for example while it is busy with an internal write cycle.

Top module: `i2c_master_ctrl`

## Requirements
- R1: A command is accepted only while `cmd_ready_o` is 1, which holds only when idle. Acceptance produces exactly one start condition: SDA is pulled low while SCL stays high.
- R2: The first byte on the bus is `{cmd_addr_i, cmd_read_i}`, sent MSB first. Bit 0 of that byte is 1 for a read and 0 for a write. Each bit is sampled by the target on the rising edge of SCL.
- R3: Outside start and stop conditions, SDA never changes while SCL stays high.
- R4: The master releases SDA (`sda_oe_o`=0) during the target's acknowledge bits and during every bit the target transmits.
- R5: If the address acknowledge bit reads high (NACK), no data byte is transferred, the transaction goes straight to the stop sequence, and `nack_o` is set.
- R6: On a write, each byte is taken from `tx_data_i` when `tx_valid_i` and `tx_ready_o` are both 1. While `tx_ready_o` waits for data, SCL is held low.
- R7: On a read, each received byte appears on `rx_data_o` with `rx_valid_o`=1 and stays stable with SCL held low until `rx_ready_i` is 1.
- R8: On a read, the master drives ACK (SDA low) after every byte except the last one. After the last byte it leaves SDA high (NACK).
- R9: Every transaction ends with one half-period in which SCL is low and SDA is pulled low. SCL then rises with SDA still low, and SDA is released while SCL is high, which makes exactly one stop condition.
- R10: Every SCL high phase inside a transaction lasts exactly `HALF_CYC` system clocks.
- R11: A NACK on a written byte ends the write after that byte, with no further bytes requested, and sets `nack_o`.
- R12: `done_o` is a one-cycle pulse raised as the block returns to idle. `nack_o` holds until the next command is accepted. A write with a byte count of 0 sends only the address byte (an address-set operation).
- R13: After reset, SCL is high, SDA is released, `cmd_ready_o` is 1, and `done_o`, `nack_o`, `tx_ready_o` and `rx_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Block is idle and will accept a command |
| cmd_addr_i | input | 7 | Target address |
| cmd_read_i | input | 1 | 1 = read, 0 = write |
| cmd_len_i | input | LEN_W | Number of data bytes |
| tx_data_i | input | 8 | Byte to write |
| tx_valid_i | input | 1 | `tx_data_i` is valid |
| tx_ready_o | output | 1 | Block wants the next write byte |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | `rx_data_o` holds a new byte |
| rx_ready_i | input | 1 | User takes the received byte |
| done_o | output | 1 | Transaction finished (one-cycle pulse) |
| nack_o | output | 1 | Last transaction ended on a NACK |
| scl_o | output | 1 | SCL level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sensed SDA level |

## Verification
The per-cycle properties cover the following:
- the idle line levels;
- SDA staying still while SCL is high, except for start and stop;
- SDA released in target-driven bits;
- SCL held low while either byte handshake waits;
- the exact SCL high time;
- SDA low at the stop's SCL rise;
- the shape of the done pulse.

The byte-level content cannot be seen from a single cycle and is left to the bench's scenarios, which run against a behavioural target on the bus. That content includes the address byte and its direction bit, the write data, the read data with the master's ACK/NACK pattern, the early ends on address or data NACK, the zero-length write, and the sticky error flag.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_ADDR_ACK, ST_WAIT_TX, ST_TX, ST_TX_ACK,
    ST_RX, ST_RX_HOLD, ST_RX_ACK, ST_PREP, ST_STOP
  } st_e;
endpackage

// File: rtl/i2cm_clkdiv.sv
module i2cm_clkdiv #(
  parameter int unsigned HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/i2cm_bitseq.sv
// half-bit phase (0: SCL low, 1: SCL high) and bit index within a byte
module i2cm_bitseq #(
  parameter int unsigned BIT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic             ph_o,
  output logic [BIT_W-1:0] bit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_o  <= 1'b0;
      bit_o <= '0;
    end else if (clr_i) begin
      ph_o  <= 1'b0;
      bit_o <= '0;
    end else if (tick_i) begin
      ph_o <= ~ph_o;
      if (ph_o) bit_o <= bit_o + 1'b1;
    end
  end
endmodule

// File: rtl/i2cm_shreg.sv
module i2cm_shreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (load_i) q_o <= load_val_i;
    else if (shift_i) q_o <= {q_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/i2c_master_ctrl.sv
module i2c_master_ctrl
  import i2cm_pkg::*;
#(
  parameter int unsigned HALF_CYC = 4,
  parameter int unsigned LEN_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [6:0]       cmd_addr_i,
  input  logic             cmd_read_i,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  input  logic             rx_ready_i,
  output logic             done_o,
  output logic             nack_o,
  output logic             scl_o,
  output logic             sda_oe_o,
  input  logic             sda_i
);
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_W  = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  st_e st_q, st_n;
  logic [LEN_W-1:0] rem_q, rem_n;
  logic rd_q, rd_n, nack_q, nack_n, done_q;
  logic tick, ph, run, clr, shift;
  logic [BIT_W-1:0] bitc;
  logic sh_load;
  logic [BYTE_W-1:0] sh_val, sh_q;
  logic bit_end, byte_end;

  assign run = !(st_q inside {ST_IDLE, ST_WAIT_TX, ST_RX_HOLD});
  assign clr = (st_n != st_q);
  assign bit_end  = tick && ph;
  assign byte_end = bit_end && (bitc == LAST_BIT);
  assign shift    = bit_end && (st_q inside {ST_ADDR, ST_TX, ST_RX});

  i2cm_clkdiv #(.HALF_CYC(HALF_CYC)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_o(tick)
  );

  i2cm_bitseq #(.BIT_W(BIT_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .tick_i(tick),
    .ph_o(ph), .bit_o(bitc)
  );

  i2cm_shreg #(.W(BYTE_W)) u_sh (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(sh_load), .load_val_i(sh_val),
    .shift_i(shift), .bit_i(sda_i), .q_o(sh_q)
  );

  always_comb begin
    st_n    = st_q;
    rem_n   = rem_q;
    rd_n    = rd_q;
    nack_n  = nack_q;
    sh_load = 1'b0;
    sh_val  = '0;
    unique case (st_q)
      ST_IDLE: if (cmd_valid_i) begin
        st_n    = ST_START;
        rem_n   = cmd_len_i;
        rd_n    = cmd_read_i;
        nack_n  = 1'b0;
        sh_load = 1'b1;
        sh_val  = {cmd_addr_i, cmd_read_i};
      end
      ST_START: if (tick) st_n = ST_ADDR;
      ST_ADDR:  if (byte_end) st_n = ST_ADDR_ACK;
      ST_ADDR_ACK: if (bit_end) begin
        if (sda_i) begin
          nack_n = 1'b1;
          st_n   = ST_PREP;
        end else if (rem_q == '0) st_n = ST_PREP;
        else if (rd_q) st_n = ST_RX;
        else st_n = ST_WAIT_TX;
      end
      ST_WAIT_TX: if (tx_valid_i) begin
        sh_load = 1'b1;
        sh_val  = tx_data_i;
        st_n    = ST_TX;
      end
      ST_TX: if (byte_end) st_n = ST_TX_ACK;
      ST_TX_ACK: if (bit_end) begin
        rem_n = rem_q - 1'b1;
        if (sda_i) begin
          nack_n = 1'b1;
          st_n   = ST_PREP;
        end else if (rem_q == ONE) st_n = ST_PREP;
        else st_n = ST_WAIT_TX;
      end
      ST_RX:      if (byte_end) st_n = ST_RX_HOLD;
      ST_RX_HOLD: if (rx_ready_i) st_n = ST_RX_ACK;
      ST_RX_ACK: if (bit_end) begin
        rem_n = rem_q - 1'b1;
        st_n  = (rem_q == ONE) ? ST_PREP : ST_RX;
      end
      ST_PREP: if (tick) st_n = ST_STOP;
      ST_STOP: if (bit_end) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      rd_q   <= 1'b0;
      nack_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      rem_q  <= rem_n;
      rd_q   <= rd_n;
      nack_q <= nack_n;
      done_q <= (st_q == ST_STOP) && (st_n == ST_IDLE);
    end
  end

  // line decode from registered state
  always_comb begin
    scl_o    = 1'b1;
    sda_oe_o = 1'b0;
    unique case (st_q)
      ST_IDLE:  ;
      ST_START: sda_oe_o = 1'b1;
      ST_ADDR, ST_TX: begin
        scl_o    = ph;
        sda_oe_o = !sh_q[BYTE_W-1];
      end
      ST_ADDR_ACK, ST_TX_ACK, ST_RX: scl_o = ph;
      ST_WAIT_TX, ST_RX_HOLD: scl_o = 1'b0;
      ST_RX_ACK: begin
        scl_o    = ph;
        sda_oe_o = (rem_q != ONE);
      end
      ST_PREP: begin
        scl_o    = 1'b0;
        sda_oe_o = 1'b1;
      end
      ST_STOP: sda_oe_o = !ph;
      default: ;
    endcase
  end

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign tx_ready_o  = (st_q == ST_WAIT_TX);
  assign rx_valid_o  = (st_q == ST_RX_HOLD);
  assign rx_data_o   = sh_q;
  assign done_o      = done_q;
  assign nack_o      = nack_q;
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
  import i2cm_pkg::*;
#(
  parameter int unsigned HALF_CYC = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input st_e        st_i,
  input logic       cmd_ready_o,
  input logic       tx_ready_o,
  input logic       rx_valid_o,
  input logic       rx_ready_i,
  input logic [7:0] rx_data_o,
  input logic       done_o,
  input logic       scl_o,
  input logic       sda_oe_o
);
  logic        scl_d, oe_d, rose_seen;
  logic [31:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d     <= 1'b1;
      oe_d      <= 1'b0;
      rose_seen <= 1'b0;
      hi_cnt    <= '0;
    end else begin
      scl_d <= scl_o;
      oe_d  <= sda_oe_o;
      if (scl_o && !scl_d) begin
        hi_cnt    <= 32'd1;
        rose_seen <= 1'b1;
      end else if (scl_o) hi_cnt <= hi_cnt + 32'd1;
      if (cmd_ready_o) rose_seen <= 1'b0;
    end
  end

  assert_idle_lines_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (scl_o && !sda_oe_o));

  assert_sda_still_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && scl_d && (sda_oe_o != oe_d)) |-> (st_i == ST_START || st_i == ST_STOP));

  assert_target_bits_released_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i inside {ST_ADDR_ACK, ST_TX_ACK, ST_RX}) |-> !sda_oe_o);

  assert_tx_stretch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> !scl_o);

  assert_rx_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o) && !scl_o));

  assert_stop_rise_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && !scl_d && st_i == ST_STOP) |-> sda_oe_o);

  assert_high_time_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_o && scl_d && rose_seen) |-> (hi_cnt == 32'(HALF_CYC)));

  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_ready_o);

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind i2c_master_ctrl i2cm_checker #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .st_i(st_q), .cmd_ready_o(cmd_ready_o),
  .tx_ready_o(tx_ready_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
  .rx_data_o(rx_data_o), .done_o(done_o), .scl_o(scl_o), .sda_oe_o(sda_oe_o)
);

// File: tb/i2c_master_ctrl_tb_top.sv
`timescale 1ns/1ps
module i2c_master_ctrl_tb_top;
  localparam int HALF = 4;
  localparam int LW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cmd_valid = 1'b0, cmd_read = 1'b0;
  logic [6:0]    cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic [7:0]    tx_data = '0;
  logic          tx_valid = 1'b0, rx_ready = 1'b0;
  logic          cmd_ready, tx_ready, rx_valid, done, nack, scl, sda_oe, sda_in;
  logic [7:0]    rx_data;
  logic          s_pull = 1'b0;

  assign sda_in = !(sda_oe || s_pull);

  i2c_master_ctrl #(.HALF_CYC(HALF), .LEN_W(LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_addr_i(cmd_addr), .cmd_read_i(cmd_read), .cmd_len_i(cmd_len),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .done_o(done), .nack_o(nack), .scl_o(scl), .sda_oe_o(sda_oe), .sda_i(sda_in)
  );

  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_pat(input logic [7:0] b, input int k);
    return b ^ 8'((k * 59 + 17) & 255);
  endfunction

  // behavioural target device plus line monitors
  bit         cfg_nack_addr = 0;
  int         cfg_nack_at = -1;
  logic [7:0] cfg_base = '0;
  int   s_mode = 0, s_bit = 0, s_starts = 0, s_stops = 0, s_wr_cnt = 0, s_rd_idx = 0, s_conf = 0;
  bit   s_ack = 0, s_prev_scl = 1, s_prev_line = 1, s_line;
  logic [7:0] s_sh = '0, s_addr = '0, s_cur;
  logic [7:0] s_wr [16];
  bit   s_mack [16];
  int   hi = 0, hi_err = 0;
  bit   hseen = 0, m_prev_scl = 1;

  always @(negedge clk) begin
    s_line = !(sda_oe || s_pull);
    if (scl && s_prev_scl && s_prev_line && !s_line) begin
      s_starts++; s_mode = 1; s_bit = -1; s_sh = '0; s_pull = 1'b0;
    end else if (scl && s_prev_scl && !s_prev_line && s_line) begin
      s_stops++; s_mode = 0; s_pull = 1'b0;
    end else if (scl && !s_prev_scl && s_mode >= 1 && s_mode <= 3) begin
      if (s_bit < 8) begin
        if (s_mode != 3) s_sh = {s_sh[6:0], s_line};
        else if (sda_oe) s_conf++;
      end else begin
        if (s_mode == 3) begin
          s_mack[s_rd_idx] = s_line; s_rd_idx++;
          if (s_line) s_mode = 4;
        end else if (sda_oe) s_conf++;
      end
    end else if (!scl && s_prev_scl && s_mode >= 1 && s_mode <= 3) begin
      if (s_bit == 7) begin
        s_bit = 8;
        if (s_mode == 3) s_pull = 1'b0;
        else if (s_mode == 1) begin
          s_addr = s_sh; s_ack = !cfg_nack_addr; s_pull = s_ack;
        end else begin
          s_wr[s_wr_cnt] = s_sh; s_ack = (s_wr_cnt != cfg_nack_at); s_wr_cnt++; s_pull = s_ack;
        end
      end else if (s_bit == 8) begin
        s_bit = 0; s_pull = 1'b0;
        if (s_mode == 1) begin
          if (!s_ack) s_mode = 4;
          else if (s_addr[0]) begin
            s_mode = 3; s_cur = rd_pat(cfg_base, s_rd_idx); s_pull = !s_cur[7];
          end else s_mode = 2;
        end else if (s_mode == 2) begin
          if (!s_ack) s_mode = 4;
        end else begin
          s_cur = rd_pat(cfg_base, s_rd_idx); s_pull = !s_cur[7];
        end
      end else begin
        s_bit++;
        if (s_mode == 3 && s_bit >= 0) begin
          s_cur = rd_pat(cfg_base, s_rd_idx); s_pull = !s_cur[7 - s_bit];
        end
      end
    end
    s_prev_scl  = scl;
    s_prev_line = !(sda_oe || s_pull);
    // SCL high-time monitor
    if (scl) begin
      if (!m_prev_scl) begin hi = 1; hseen = 1; end
      else hi++;
    end else if (m_prev_scl && hseen && hi != HALF) hi_err++;
    if (cmd_ready) hseen = 0;
    m_prev_scl = scl;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic run_txn(input logic [6:0] a, input bit rd, input int len,
                         input bit nack_addr, input int nack_at, input int maxdly);
    logic [7:0] txb [16];
    logic [7:0] rxb [16];
    int  exp_wr, exp_rx, tx_idx, rx_idx, dly_t, dly_r, cyc, stretch_err, bad;
    bit  exp_nack, tx_fire, rx_fire, got_done;
    exp_nack = nack_addr || (!rd && nack_at >= 0 && nack_at < len);
    exp_wr = (rd || nack_addr) ? 0 : ((nack_at >= 0 && nack_at < len) ? nack_at + 1 : len);
    exp_rx = (rd && !nack_addr) ? len : 0;
    for (int k = 0; k < 16; k++) txb[k] = 8'($urandom);
    @(negedge clk);
    cfg_nack_addr = nack_addr; cfg_nack_at = nack_at; cfg_base = 8'($urandom);
    s_starts = 0; s_stops = 0; s_wr_cnt = 0; s_rd_idx = 0; s_conf = 0; hi_err = 0;
    cmd_valid = 1'b1; cmd_addr = a; cmd_read = rd; cmd_len = LW'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
    tx_idx = 0; rx_idx = 0; dly_t = $urandom_range(maxdly, 0); dly_r = $urandom_range(maxdly, 0);
    tx_fire = 0; rx_fire = 0; got_done = 0; cyc = 0; stretch_err = 0;
    while (!got_done && cyc < 20000) begin
      @(negedge clk); cyc++;
      if (tx_fire) begin tx_idx++; tx_valid = 1'b0; dly_t = $urandom_range(maxdly, 0); end
      if (rx_fire) begin rx_ready = 1'b0; dly_r = $urandom_range(maxdly, 0); end
      if (tx_ready && !tx_valid) begin
        if (scl) stretch_err++;
        if (dly_t == 0) begin tx_valid = 1'b1; tx_data = txb[tx_idx & 15]; end
        else dly_t--;
      end
      if (rx_valid && !rx_ready) begin
        if (scl) stretch_err++;
        if (dly_r == 0) rx_ready = 1'b1;
        else dly_r--;
      end
      tx_fire = tx_valid && tx_ready;
      rx_fire = rx_ready && rx_valid;
      if (rx_fire) begin rxb[rx_idx & 15] = rx_data; rx_idx++; end
      if (done) got_done = 1;
    end
    chk(got_done, "R12 done seen", got_done, 1);
    @(negedge clk);
    chk(!done, "R12 done one cycle", done, 0);
    chk(s_starts == 1, "R1 start count", s_starts, 1);
    chk(s_stops == 1, "R9 stop count", s_stops, 1);
    chk(s_addr == {a, rd}, "R2 address byte", s_addr, {a, rd});
    chk(nack == exp_nack, exp_nack ? "R5/R11 nack flag set" : "R5 nack flag clear", nack, exp_nack);
    chk(tx_idx == exp_wr, "R6 R11 bytes requested", tx_idx, exp_wr);
    chk(s_wr_cnt == exp_wr, "R6 R12 bytes on bus", s_wr_cnt, exp_wr);
    bad = 0;
    for (int k = 0; k < exp_wr && k < s_wr_cnt; k++) if (s_wr[k] != txb[k]) bad++;
    chk(bad == 0, "R6 write data", bad, 0);
    chk(rx_idx == exp_rx, "R7 bytes received", rx_idx, exp_rx);
    bad = 0;
    for (int k = 0; k < exp_rx && k < rx_idx; k++) if (rxb[k] != rd_pat(cfg_base, k)) bad++;
    chk(bad == 0, "R7 read data", bad, 0);
    bad = 0;
    for (int k = 0; k < exp_rx && k < s_rd_idx; k++) if (s_mack[k] != (k == exp_rx - 1)) bad++;
    chk(bad == 0 && s_rd_idx == exp_rx, "R8 master ack pattern", bad, 0);
    chk(s_conf == 0, "R4 SDA released for target", s_conf, 0);
    chk(hi_err == 0, "R10 SCL high time", hi_err, 0);
    chk(stretch_err == 0, "R6 R7 SCL held low while waiting", stretch_err, 0);
    repeat (5) @(negedge clk);
    chk(nack == exp_nack && cmd_ready && scl && !sda_oe, "R12 R3 flag holds, lines idle", nack, exp_nack);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(cmd_ready && scl && !sda_oe, "R13 idle lines", {cmd_ready, scl, sda_oe}, 3'b110);
    chk(!done && !nack && !tx_ready && !rx_valid, "R13 flags clear", {done, nack, tx_ready, rx_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cmd_ready && scl && !sda_oe, "R13 idle after release", {cmd_ready, scl, sda_oe}, 3'b110);
    run_txn(7'h50, 0, 1, 0, -1, 0);
    run_txn(7'h53, 1, 1, 0, -1, 0);
    run_txn(7'h51, 0, 0, 0, -1, 0);    // R12 address-only write
    run_txn(7'h52, 0, 3, 1, -1, 2);    // R5 address NACK on write
    run_txn(7'h52, 1, 4, 1, -1, 2);    // R5 address NACK on read
    run_txn(7'h50, 0, 5, 0, 2, 3);     // R11 NACK on third byte
    run_txn(7'h50, 0, 3, 0, 2, 1);     // R11 NACK on final byte
    run_txn(7'h57, 1, 15, 0, -1, 6);   // R7 R8 long read with stalls
    run_txn(7'h7F, 0, 15, 0, -1, 6);   // R6 long write with stalls
    for (int t = 0; t < 20; t++) begin
      logic rd_r;
      int   len_r, na;
      rd_r  = 1'($urandom_range(1, 0));
      len_r = $urandom_range(15, rd_r ? 1 : 0);
      na    = ($urandom_range(5, 0) == 0) ? $urandom_range(len_r, 0) : -1;
      run_txn(7'($urandom), rd_r, len_r, $urandom_range(7, 0) == 0, na, $urandom_range(8, 0));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule